// File: doc/BRIEF.md
# Split-Word Look-Ahead Canonic Signed Digit Recoder

This block turns a two's complement operand into canonic signed digit (CSD) form. CSD is the non-adjacent signed-digit form: every digit is -1, 0 or +1, and no two neighbouring digits are both non-zero. The block is pipelined over two register stages. The operand is captured first. The recoded digits are registered one cycle later, as a pair of flags per digit position.

The operand is split into a lower and an upper half word. The lower half works out its carries with a bit-by-bit ripple. A purely combinational look-ahead generator also scans the lower half, four bits per step, and produces the carry into the upper half, so the upper ripple does not wait for the whole lower ripple. Each group step uses the group's four bits plus the lowest bit of the next group, so neighbouring groups share a boundary bit. The look-ahead generator holds no flip-flops.

For test, the flip-flops of each half are stitched into their own shift register, which gives two independent scan paths. The lower path enters where the lower carry-in is injected. The upper path has a dedicated serial input, because its carry-in comes from the look-ahead logic. The operand width is a parameter and must be a multiple of 8.

Top module: `csd_la_recoder`

## Requirements
- R1: While rst_n is low, every bit of digit_pos and digit_neg reads 0, and both scan outputs read 0.
- R2: In functional mode (test_mode=0), the operand driven before a clock edge appears as digits after the following edge. Digit i is worth +2^i when digit_pos[i]=1, -2^i when digit_neg[i]=1, and 0 when both are 0. The digits sum to the signed operand value.
- R3: After a functional capture, digit_pos[i] and digit_neg[i] are never both 1.
- R4: After a functional capture, no two adjacent digit positions are both non-zero, so the result is the unique non-adjacent form of the operand.
- R5: The carry into the upper half, produced by the four-bit look-ahead groups, equals the carry a full bit-by-bit ripple over the lower half gives. The upper digits therefore match a serial recoder for every operand, including long runs of ones across the half boundary.
- R6: With test_mode=1, the lower path shifts one position per clock. The order is scan_in_lo, then operand bits 0 up to OP_W/2-1, then for each lower digit i in rising order the pair (digit_pos[i], digit_neg[i]), then scan_out_lo. The path has 3*OP_W/2 stages.
- R7: With test_mode=1, the upper path shifts in the same way from scan_in_hi, through operand bits OP_W/2 up to OP_W-1 and the upper digit pairs, to scan_out_hi. No bit crosses between the two paths.
- R8: With test_mode=0, both register stages load their functional values on every clock, and scan_in_lo and scan_in_hi have no effect on the digits.
- R9: An operand value loaded into the operand register through the scan paths is recoded by the next functional clock. Digits captured in functional mode can be unloaded through the scan outputs by switching to test_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = shift both scan paths, 0 = functional capture |
| operand | input | OP_W | Two's complement operand |
| scan_in_lo | input | 1 | Serial input of the lower path (lower carry-in during shift) |
| scan_in_hi | input | 1 | Serial input of the upper path |
| digit_pos | output | OP_W | Per-digit +1 flag |
| digit_neg | output | OP_W | Per-digit -1 flag |
| scan_out_lo | output | 1 | Serial output of the lower path |
| scan_out_hi | output | 1 | Serial output of the upper path |

## Verification
The hardest case to reach is a look-ahead carry of 1 into the upper half that comes from a carry run started deep in the lower half. The upper digits are only correct if every group step passes the run on. Directed operands place runs of ones so that they end exactly at, just below and just above the half boundary, and a long stream of pseudo-random operands covers the rest. The other hard case is an operand register that holds a value which never appeared on the operand port. The bench shifts a value into both paths, drives a different operand, and applies a single functional clock, so the digits can only come from the scanned value.

// File: rtl/csd_la_pkg.sv
package csd_la_pkg;

  // carry rule of the recoder: majority of the bit, its upper neighbour and the incoming carry
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a | b));
  endfunction

  // digit flags from the bit, its carry-in and its carry-out
  function automatic logic dig_pos(input logic x, input logic cin, input logic cout);
    return (x ^ cin) & ~cout;
  endfunction

  function automatic logic dig_neg(input logic x, input logic cin, input logic cout);
    return (x ^ cin) & cout;
  endfunction

  // group generate / propagate over five bits (four carry steps), bit 4 is the shared boundary
  typedef struct packed {
    logic gen;
    logic prop;
  } grp_gp_t;

  function automatic grp_gp_t group_gp(input logic [4:0] x);
    logic [3:0] g;
    logic [3:0] p;
    grp_gp_t    r;
    for (int j = 0; j < 4; j++) begin
      g[j] = x[j] & x[j+1];
      p[j] = x[j] | x[j+1];
    end
    r.gen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
    r.prop = &p;
    return r;
  endfunction

endpackage

// File: rtl/csd_ripple_half.sv
module csd_ripple_half
  import csd_la_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0]   x,
  input  logic         cin,
  output logic [W-1:0] pos,
  output logic [W-1:0] neg
);

  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = maj3(x[i], x[i+1], carry[i]);
    assign pos[i]     = dig_pos(x[i], carry[i], carry[i+1]);
    assign neg[i]     = dig_neg(x[i], carry[i], carry[i+1]);
  end

endmodule

// File: rtl/csd_la_carry_gen.sv
module csd_la_carry_gen
  import csd_la_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0] x,
  input  logic       cin,
  output logic       cout
);

  localparam int NGRP = W / 4;

  logic [NGRP:0] gcarry;

  assign gcarry[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    grp_gp_t gp;
    assign gp          = group_gp(x[4*k+4 : 4*k]);
    assign gcarry[k+1] = gp.gen | (gp.prop & gcarry[k]);
  end

  assign cout = gcarry[NGRP];

endmodule

// File: rtl/csd_scan_half.sv
module csd_scan_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         scan_in,
  input  logic [W-1:0] op_in,
  input  logic [W-1:0] pos_in,
  input  logic [W-1:0] neg_in,
  output logic [W-1:0] op_q,
  output logic [W-1:0] pos_q,
  output logic [W-1:0] neg_q,
  output logic         scan_out
);

  localparam int L = 3 * W;

  logic [L-1:0] chain;
  logic [L-1:0] func_next;

  always_comb begin
    func_next[W-1:0] = op_in;
    for (int j = 0; j < W; j++) begin
      func_next[W + 2*j]     = pos_in[j];
      func_next[W + 2*j + 1] = neg_in[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chain <= '0;
    else if (test_mode) chain <= {chain[L-2:0], scan_in};
    else                chain <= func_next;
  end

  always_comb begin
    op_q = chain[W-1:0];
    for (int j = 0; j < W; j++) begin
      pos_q[j] = chain[W + 2*j];
      neg_q[j] = chain[W + 2*j + 1];
    end
  end

  assign scan_out = chain[L-1];

endmodule

// File: rtl/csd_la_recoder.sv
module csd_la_recoder #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_mode,
  input  logic [OP_W-1:0] operand,
  input  logic            scan_in_lo,
  input  logic            scan_in_hi,
  output logic [OP_W-1:0] digit_pos,
  output logic [OP_W-1:0] digit_neg,
  output logic            scan_out_lo,
  output logic            scan_out_hi
);

  localparam int H = OP_W / 2;

  logic [OP_W-1:0] op_q;
  logic [OP_W:0]   op_ext;
  logic            c_lo_in;
  logic            c_mid;
  logic [OP_W-1:0] pos_d;
  logic [OP_W-1:0] neg_d;

  // the lower carry-in doubles as the lower scan entry; functional mode forces it to 0
  assign c_lo_in = scan_in_lo & test_mode;
  assign op_ext  = {op_q[OP_W-1], op_q};

  csd_ripple_half #(.W(H)) u_rip_lo (
    .x   (op_ext[H:0]),
    .cin (c_lo_in),
    .pos (pos_d[H-1:0]),
    .neg (neg_d[H-1:0])
  );

  csd_la_carry_gen #(.W(H)) u_la (
    .x    (op_ext[H:0]),
    .cin  (c_lo_in),
    .cout (c_mid)
  );

  csd_ripple_half #(.W(H)) u_rip_hi (
    .x   (op_ext[OP_W:H]),
    .cin (c_mid),
    .pos (pos_d[OP_W-1:H]),
    .neg (neg_d[OP_W-1:H])
  );

  csd_scan_half #(.W(H)) u_scan_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_in   (scan_in_lo),
    .op_in     (operand[H-1:0]),
    .pos_in    (pos_d[H-1:0]),
    .neg_in    (neg_d[H-1:0]),
    .op_q      (op_q[H-1:0]),
    .pos_q     (digit_pos[H-1:0]),
    .neg_q     (digit_neg[H-1:0]),
    .scan_out  (scan_out_lo)
  );

  csd_scan_half #(.W(H)) u_scan_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_in   (scan_in_hi),
    .op_in     (operand[OP_W-1:H]),
    .pos_in    (pos_d[OP_W-1:H]),
    .neg_in    (neg_d[OP_W-1:H]),
    .op_q      (op_q[OP_W-1:H]),
    .pos_q     (digit_pos[OP_W-1:H]),
    .neg_q     (digit_neg[OP_W-1:H]),
    .scan_out  (scan_out_hi)
  );

endmodule

// File: rtl/csd_la_recoder_chk.sv
module csd_la_recoder_chk
  import csd_la_pkg::*;
#(
  parameter int OP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            test_mode,
  input logic [OP_W-1:0] operand,
  input logic            scan_in_lo,
  input logic            scan_in_hi,
  input logic [OP_W-1:0] digit_pos,
  input logic [OP_W-1:0] digit_neg,
  input logic [OP_W-1:0] op_q,
  input logic            c_lo_in,
  input logic            c_mid
);

  localparam int H = OP_W / 2;

  logic [1:0]      age;
  logic            ripple_mid;
  logic [OP_W:0]   op_in_ext;
  logic [OP_W:0]   digit_sum;
  logic [OP_W-1:0] nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    ripple_mid = c_lo_in;
    for (int i = 0; i < H; i++) ripple_mid = maj3(op_q[i], op_q[i+1], ripple_mid);
  end

  assign op_in_ext = {operand[OP_W-1], operand};
  assign digit_sum = {1'b0, digit_pos} - {1'b0, digit_neg};
  assign nz        = digit_pos | digit_neg;

  // R2: digit value equals the operand captured two clocks earlier
  a_r2_value: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(test_mode) && !$past(test_mode, 2)) |-> digit_sum == $past(op_in_ext, 2));

  // R3: never +1 and -1 at one position
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !$past(test_mode)) |-> (digit_pos & digit_neg) == '0);

  // R4: non-adjacency
  a_r4_nonadjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !$past(test_mode)) |-> (nz & (nz >> 1)) == '0);

  // R5: look-ahead carry equals bit-by-bit ripple
  a_r5_la_matches_ripple: assert property (@(posedge clk) disable iff (!rst_n)
    c_mid == ripple_mid);

  // R6: lower path entry and first digit pair shift order
  a_r6_lo_entry: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> op_q[0] == $past(scan_in_lo));

  a_r6_lo_pair: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> digit_neg[0] == $past(digit_pos[0]));

  // R7: upper path entry and boundary between operand bits and digits
  a_r7_hi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> op_q[H] == $past(scan_in_hi));

  a_r7_hi_link: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> digit_pos[H] == $past(op_q[OP_W-1]));

  // R8: functional capture of the operand
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> op_q == $past(operand));

endmodule

bind csd_la_recoder csd_la_recoder_chk #(.OP_W(OP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .test_mode  (test_mode),
  .operand    (operand),
  .scan_in_lo (scan_in_lo),
  .scan_in_hi (scan_in_hi),
  .digit_pos  (digit_pos),
  .digit_neg  (digit_neg),
  .op_q       (op_q),
  .c_lo_in    (c_lo_in),
  .c_mid      (c_mid)
);

// File: tb/csd_la_recoder_bench.sv
`timescale 1ns/1ps
module csd_la_recoder_bench;

  localparam int N = 16;
  localparam int H = N / 2;
  localparam int L = 3 * H;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_mode = 1'b0;
  logic [N-1:0] operand = '0;
  logic         scan_in_lo = 1'b0;
  logic         scan_in_hi = 1'b0;
  logic [N-1:0] digit_pos;
  logic [N-1:0] digit_neg;
  logic         scan_out_lo;
  logic         scan_out_hi;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  csd_la_recoder #(.OP_W(N)) u_csd_la_recoder (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .operand(operand),
    .scan_in_lo(scan_in_lo), .scan_in_hi(scan_in_hi),
    .digit_pos(digit_pos), .digit_neg(digit_neg),
    .scan_out_lo(scan_out_lo), .scan_out_hi(scan_out_hi)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // non-adjacent form by repeated halving of the signed value
  task automatic naf(input logic [N-1:0] v, output logic [N-1:0] p, output logic [N-1:0] q);
    longint s;
    s = longint'($signed(v));
    p = '0;
    q = '0;
    for (int i = 0; i < N; i++) begin
      if ((s & 1) != 0) begin
        if ((s & 3) == 1) begin p[i] = 1'b1; s = s - 1; end
        else              begin q[i] = 1'b1; s = s + 1; end
      end
      s = s >>> 1;
    end
  endtask

  task automatic check_digits(input logic [N-1:0] v, input string req);
    logic [N-1:0] ep, en, nz;
    naf(v, ep, en);
    chk({digit_pos, digit_neg} == {ep, en}, req, {digit_pos, digit_neg}, {ep, en});
    nz = digit_pos | digit_neg;
    chk((digit_pos & digit_neg) == '0, "R3", digit_pos & digit_neg, 0);
    chk((nz & (nz >> 1)) == '0, "R4", nz, 0);
  endtask

  task automatic t_reset();
    operand = 16'hBEEF; scan_in_lo = 1'b1; scan_in_hi = 1'b1;
    tick(); tick();
    chk(digit_pos == '0 && digit_neg == '0, "R1 digits", {digit_pos, digit_neg}, 0);
    chk(!scan_out_lo && !scan_out_hi, "R1 scan outs", {scan_out_lo, scan_out_hi}, 0);
    scan_in_lo = 1'b0; scan_in_hi = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic t_directed(input logic [N-1:0] v, input string req);
    operand = v;
    tick(); tick();
    check_digits(v, req);
  endtask

  // R5: runs of ones ending near the half boundary; upper half checked on its own
  task automatic t_boundary();
    logic [N-1:0] pats [8] = '{16'h00FF, 16'h007F, 16'h01FF, 16'h0F78,
                               16'h7FFF, 16'hFF80, 16'h80FF, 16'h3F7C};
    logic [N-1:0] ep, en;
    for (int k = 0; k < 8; k++) begin
      operand = pats[k];
      tick(); tick();
      naf(pats[k], ep, en);
      chk({digit_pos[N-1:H], digit_neg[N-1:H]} == {ep[N-1:H], en[N-1:H]}, "R5 upper half",
          {digit_pos[N-1:H], digit_neg[N-1:H]}, {ep[N-1:H], en[N-1:H]});
    end
  endtask

  // R2/R5/R8: back-to-back operands with the scan inputs toggling
  task automatic t_stream();
    logic [N-1:0] prev;
    prev = '0;
    for (int k = 0; k < 300; k++) begin
      lfsr = next_rand(lfsr);
      operand = lfsr[N-1:0];
      scan_in_lo = lfsr[20];
      scan_in_hi = lfsr[25];
      tick();
      if (k > 0) check_digits(prev, "R8 R2 R5 stream");
      prev = operand;
    end
    scan_in_lo = 1'b0; scan_in_hi = 1'b0;
  endtask

  // R6/R7: shift two different streams, check digit ports then unload
  task automatic t_shift();
    logic [L-1:0] a, b, ga, gb;
    logic [N-1:0] ep, en;
    a = 24'hC3A5_96; b = 24'h1E_7F20;
    test_mode = 1'b1;
    for (int j = 0; j < L; j++) begin
      scan_in_lo = a[j]; scan_in_hi = b[j];
      tick();
    end
    // bit j sits at path index L-1-j; digit pair i at index H+2i, H+2i+1
    for (int i = 0; i < H; i++) begin
      ep[i] = a[L-1-(H+2*i)];   en[i] = a[L-1-(H+2*i+1)];
      ep[H+i] = b[L-1-(H+2*i)]; en[H+i] = b[L-1-(H+2*i+1)];
    end
    chk(digit_pos[H-1:0] == ep[H-1:0] && digit_neg[H-1:0] == en[H-1:0], "R6 lower order",
        {digit_pos[H-1:0], digit_neg[H-1:0]}, {ep[H-1:0], en[H-1:0]});
    chk(digit_pos[N-1:H] == ep[N-1:H] && digit_neg[N-1:H] == en[N-1:H], "R7 upper order",
        {digit_pos[N-1:H], digit_neg[N-1:H]}, {ep[N-1:H], en[N-1:H]});
    for (int j = 0; j < L; j++) begin
      ga[j] = scan_out_lo; gb[j] = scan_out_hi;
      scan_in_lo = 1'b0; scan_in_hi = 1'b0;
      tick();
    end
    chk(ga == a, "R6 lower length", ga, a);
    chk(gb == b, "R7 upper length", gb, b);
    test_mode = 1'b0;
  endtask

  // R9: scan-load an operand, recode it with one functional clock
  task automatic t_scan_recode(input logic [N-1:0] v);
    test_mode = 1'b1;
    for (int j = 0; j < L; j++) begin
      scan_in_lo = (j >= 2*H) ? v[L-1-j] : 1'b0;
      scan_in_hi = (j >= 2*H) ? v[H + L-1-j] : 1'b0;
      tick();
    end
    scan_in_lo = 1'b0; scan_in_hi = 1'b0;
    test_mode = 1'b0;
    operand = ~v;
    tick();
    check_digits(v, "R9 scan-loaded");
    tick();
    check_digits(~v, "R8 after scan");
  endtask

  // R9/R6: capture digits functionally, unload both paths
  task automatic t_capture_unload(input logic [N-1:0] v);
    logic [N-1:0] ep, en;
    logic [L-1:0] elo, ehi, glo, ghi;
    operand = v;
    tick(); tick();
    naf(v, ep, en);
    for (int k = 0; k < H; k++) begin
      elo[k] = v[k]; ehi[k] = v[H+k];
      elo[H+2*k] = ep[k];   elo[H+2*k+1] = en[k];
      ehi[H+2*k] = ep[H+k]; ehi[H+2*k+1] = en[H+k];
    end
    test_mode = 1'b1;
    for (int k = 0; k < L; k++) begin
      glo[L-1-k] = scan_out_lo; ghi[L-1-k] = scan_out_hi;
      tick();
    end
    chk(glo == elo, "R9 R6 lower unload", glo, elo);
    chk(ghi == ehi, "R9 R7 upper unload", ghi, ehi);
    test_mode = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R1-all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_directed(16'h0000, "R2 zero");
    t_directed(16'hFFFF, "R2 minus one");
    t_directed(16'h7FFF, "R2 max positive");
    t_directed(16'h8000, "R2 min negative");
    t_directed(16'h5555, "R2 alternating");
    t_directed(16'hAAAA, "R2 alternating neg");
    t_directed(16'h6DB6, "R4 dense runs");
    t_boundary();
    t_stream();
    t_shift();
    t_scan_recode(16'h77F3);
    t_scan_recode(16'h80FF);
    t_capture_unload(16'h3AF7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule